// File: doc/BRIEF.md
# Polarity-Selecting Alternating Run Decoder

This block expands a serial stream of variable-length codewords into scan bits. Each codeword describes one run of identical bits. The value of the run comes from the first bit of the codeword: a leading one produces a run of ones, and a leading zero produces a run of zeros. The codeword has two parts. A group prefix made of repeated copies of the leading bit fixes a length range. A tail of the same length as the group number then picks one length inside that range.

Compressed bits enter one per cycle through a valid/ready handshake. After the last tail bit is taken, the decoder drives the run onto its output one bit per cycle, marking each bit with a valid strobe. It then adds one bit of the opposite value, which closes the run. Input is stalled for as long as output is being produced. The largest group that is accepted is a parameter. A prefix that runs past that group sets a sticky error flag and puts the decoder back in its idle state.

Top module: `altrun_decoder`

## Requirements
- R1: Out of reset, in_ready is 1, out_valid is 0 and err is 0.
- R2: The first accepted bit of a codeword sets the run value. A 1 yields a run of ones and a 0 yields a run of zeros.
- R3: Group k (2 ≤ k ≤ MAX_GRP) has a prefix of k-1 copies of the leading bit followed by its complement. A k-bit tail follows, sent MSB first. The run length is 2^k-3 plus the tail value. In group 2, 1000..1011 give ones runs of 1..4 and 0100..0111 give zeros runs of 1..4. In group 3, 110000 gives five ones and 001111 gives twelve zeros.
- R4: No codeword encodes a zero-length run. A tail of all zeros in group 2 gives exactly one run bit.
- R5: A decoded run of length L appears as L bits of the run value followed by one bit of the opposite value, on L+1 consecutive cycles with out_valid high.
- R6: in_ready is 0 on every cycle that out_valid is 1. It returns to 1 on the cycle after the closing bit.
- R7: A bit is consumed only on a cycle where in_valid and in_ready are both 1. Idle cycles between codeword bits do not change the decoded output.
- R8: If MAX_GRP copies of the leading bit arrive in a row, err goes to 1 and the decoder returns to idle with in_ready 1. No output bits are produced for that prefix.
- R9: err stays 1 until reset, and decoding of later codewords goes on normally.
- R10: The largest group MAX_GRP decodes runs up to 2^(MAX_GRP+1)-4 bits. The smallest length of group 4 is 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A compressed bit is offered |
| in_bit | input | 1 | Compressed bit value |
| in_ready | output | 1 | Decoder can take a compressed bit |
| out_valid | output | 1 | out_bit carries a decoded scan bit |
| out_bit | output | 1 | Decoded scan bit |
| err | output | 1 | Sticky flag: prefix exceeded the largest group |

## Verification
The hardest state to reach from the ports is the prefix-overflow path at the exact group limit. Only a run of MAX_GRP identical leading bits reaches it. One bit fewer is a legal prefix of the largest group and must decode correctly. The stimulus sends the longest legal codeword (a 508-bit run with the default limit) and then one more copy of the leading bit for each polarity. It then checks that the following codeword decodes correctly while the flag stays set.

// File: rtl/altrun_pkg.sv
package altrun_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_PREFIX = 3'd1,
      ST_TAIL   = 3'd2,
      ST_EMIT   = 3'd3,
      ST_TERM   = 3'd4
   } dec_state_e;

   function automatic int unsigned grp_cnt_width(input int unsigned max_grp);
      return $clog2(max_grp + 1);
   endfunction

endpackage

// File: rtl/altrun_prefix_cnt.sv
module altrun_prefix_cnt #(
   parameter int unsigned MAX_GRP = 8,
   parameter int unsigned KW      = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          bump,
   output logic [KW-1:0] reps,
   output logic          at_limit
);
   logic [KW-1:0] reps_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      reps_q <= '0;
      else if (start)  reps_q <= KW'(1);
      else if (bump)   reps_q <= reps_q + KW'(1);
   end

   assign reps     = reps_q;
   assign at_limit = (reps_q == KW'(MAX_GRP - 1));
endmodule

// File: rtl/altrun_tail_reg.sv
module altrun_tail_reg #(
   parameter int unsigned MAX_GRP   = 8,
   parameter int unsigned KW        = 4,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [KW-1:0]      len_in,
   input  logic               shift,
   input  logic               bit_in,
   output logic [MAX_GRP-1:0] value_nxt,
   output logic               last
);
   logic [MAX_GRP-1:0] val_q;
   logic [KW-1:0]      rem_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= '0;
         rem_q <= '0;
      end else if (load) begin
         val_q <= '0;
         rem_q <= len_in;
      end else if (shift) begin
         val_q <= value_nxt;
         rem_q <= rem_q - KW'(1);
      end
   end

   assign last = (rem_q == KW'(1));

   generate
      if (MSB_FIRST) begin : g_msb
         assign value_nxt = {val_q[MAX_GRP-2:0], bit_in};
      end else begin : g_lsb
         logic [KW-1:0] pos_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      pos_q <= '0;
            else if (load)   pos_q <= '0;
            else if (shift)  pos_q <= pos_q + KW'(1);
         end
         assign value_nxt = val_q | ({{(MAX_GRP-1){1'b0}}, bit_in} << pos_q);
      end
   endgenerate
endmodule

// File: rtl/altrun_run_ctr.sv
module altrun_run_ctr #(
   parameter int unsigned LW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [LW-1:0] len_in,
   input  logic          step,
   output logic          last
);
   logic [LW-1:0] rem_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     rem_q <= '0;
      else if (load)  rem_q <= len_in;
      else if (step)  rem_q <= rem_q - LW'(1);
   end

   assign last = (rem_q == LW'(1));
endmodule

// File: rtl/altrun_decoder.sv
module altrun_decoder
   import altrun_pkg::*;
#(
   parameter int unsigned MAX_GRP        = 8,
   parameter bit          TAIL_MSB_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_bit,
   output logic in_ready,
   output logic out_valid,
   output logic out_bit,
   output logic err
);
   localparam int unsigned KW = grp_cnt_width(MAX_GRP);
   localparam int unsigned LW = MAX_GRP + 1;

   generate
      if (MAX_GRP < 2) begin : g_chk_min
         $error("altrun_decoder: MAX_GRP must be at least 2");
      end
      if (MAX_GRP > 30) begin : g_chk_max
         $error("altrun_decoder: MAX_GRP must not exceed 30");
      end
   endgenerate

   dec_state_e         state_q, state_d;
   logic               pol_q, err_q;
   logic               acc;
   logic               same_bit;
   logic [KW-1:0]      reps;
   logic               at_limit;
   logic [KW-1:0]      grp;
   logic [MAX_GRP-1:0] tail_nxt;
   logic               tail_last;
   logic               run_last;
   logic [LW-1:0]      run_len;

   logic pfx_start, pfx_bump, tail_load, tail_shift, run_load, run_step, set_err;

   assign in_ready  = (state_q == ST_IDLE) || (state_q == ST_PREFIX) || (state_q == ST_TAIL);
   assign acc       = in_valid && in_ready;
   assign same_bit  = (in_bit == pol_q);
   assign grp       = reps + KW'(1);
   assign run_len   = (LW'(1) << grp) - LW'(3) + {1'b0, tail_nxt};

   always_comb begin
      state_d    = state_q;
      pfx_start  = 1'b0;
      pfx_bump   = 1'b0;
      tail_load  = 1'b0;
      tail_shift = 1'b0;
      run_load   = 1'b0;
      run_step   = 1'b0;
      set_err    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (acc) begin
               pfx_start = 1'b1;
               state_d   = ST_PREFIX;
            end
         end
         ST_PREFIX: begin
            if (acc) begin
               if (same_bit) begin
                  if (at_limit) begin
                     set_err = 1'b1;
                     state_d = ST_IDLE;
                  end else begin
                     pfx_bump = 1'b1;
                  end
               end else begin
                  tail_load = 1'b1;
                  state_d   = ST_TAIL;
               end
            end
         end
         ST_TAIL: begin
            if (acc) begin
               tail_shift = 1'b1;
               if (tail_last) begin
                  run_load = 1'b1;
                  state_d  = ST_EMIT;
               end
            end
         end
         ST_EMIT: begin
            run_step = 1'b1;
            if (run_last) state_d = ST_TERM;
         end
         ST_TERM: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pol_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (pfx_start) pol_q <= in_bit;
         if (set_err)   err_q <= 1'b1;
      end
   end

   altrun_prefix_cnt #(.MAX_GRP(MAX_GRP), .KW(KW)) i_pfx (
      .clk(clk), .rst_n(rst_n), .start(pfx_start), .bump(pfx_bump),
      .reps(reps), .at_limit(at_limit)
   );

   altrun_tail_reg #(.MAX_GRP(MAX_GRP), .KW(KW), .MSB_FIRST(TAIL_MSB_FIRST)) i_tail (
      .clk(clk), .rst_n(rst_n), .load(tail_load), .len_in(grp),
      .shift(tail_shift), .bit_in(in_bit), .value_nxt(tail_nxt), .last(tail_last)
   );

   altrun_run_ctr #(.LW(LW)) i_run (
      .clk(clk), .rst_n(rst_n), .load(run_load), .len_in(run_len),
      .step(run_step), .last(run_last)
   );

   assign out_valid = (state_q == ST_EMIT) || (state_q == ST_TERM);
   assign out_bit   = (state_q == ST_EMIT) ? pol_q : ~pol_q;
   assign err       = err_q;
endmodule

// File: rtl/altrun_checker.sv
module altrun_checker (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic out_valid,
   input logic out_bit,
   input logic err
);
   // R6: input stalled while bits are emitted
   a_r6_stall_on_emit: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R6: input reopens right after the closing bit
   a_r6_reopen: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> in_ready);

   // R5: a value change inside a burst is the closing bit, which ends it
   a_r5_close_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid) && (out_bit != $past(out_bit))) |=> !out_valid);

   // R7: a burst starts only after an accepted input bit
   a_r7_burst_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready));

   // R9: error flag never clears outside reset
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R8: overflow is flagged from a prefix, never during emission
   a_r8_err_no_output: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (!out_valid && in_ready));
endmodule

bind altrun_decoder altrun_checker i_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_bit(out_bit), .err(err)
);

// File: tb/test_altrun_decoder.sv
`timescale 1ns/100ps
module test_altrun_decoder;
   localparam int MAX_GRP = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_bit = 1'b0;
   logic in_ready, out_valid, out_bit, err;

   int checks = 0;
   int failures = 0;
   int stall_viol = 0;
   logic obuf[$];
   logic exp_q[$];

   always #2.5 clk = ~clk;

   altrun_decoder #(.MAX_GRP(MAX_GRP)) i_altrun_decoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
      .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit), .err(err)
   );

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         obuf.push_back(out_bit);
         if (in_ready) stall_viol++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      obuf.delete(); exp_q.delete();
   endtask

   task automatic push(input logic b, input int gap);
      in_bit = b; in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   function automatic int grp_of(input int len);
      int k = 2;
      while (len > (1 << (k + 1)) - 4) k++;
      return k;
   endfunction

   task automatic send_code(input logic pol, input int len, input int gap);
      int k = grp_of(len);
      int tail = len - ((1 << k) - 3);
      for (int i = 0; i < k - 1; i++) push(pol, gap);
      push(~pol, gap);
      for (int i = k - 1; i >= 0; i--) push(tail[i], gap);
   endtask

   task automatic expect_run(input logic pol, input int len);
      for (int i = 0; i < len; i++) exp_q.push_back(pol);
      exp_q.push_back(~pol);
   endtask

   task automatic drain();
      while (out_valid) @(negedge clk);
   endtask

   task automatic check_stream(input string req, input string what);
      int mism = 0;
      if (obuf.size() == exp_q.size())
         for (int i = 0; i < obuf.size(); i++) if (obuf[i] !== exp_q[i]) mism++;
      chk(obuf.size() == exp_q.size(), req, {what, " length"}, obuf.size(), exp_q.size());
      chk(mism == 0, req, {what, " mismatching bits"}, mism, 0);
      chk(in_ready == 1'b1, "R6", {what, " ready after run"}, in_ready, 1);
      obuf.delete(); exp_q.delete();
   endtask

   task automatic one_case(input logic pol, input int len, input int gap, input string req, input string what);
      expect_run(pol, len);
      send_code(pol, len, gap);
      drain();
      check_stream(req, what);
   endtask

   task automatic t_reset();
      chk(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
      chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
      chk(err == 1'b0, "R1", "reset err", err, 0);
   endtask

   task automatic t_group2();
      one_case(1'b1, 1, 0, "R4", "code 1000 single one");
      one_case(1'b0, 1, 0, "R4", "code 0100 single zero");
      one_case(1'b1, 4, 0, "R2", "code 1011 four ones");
      one_case(1'b0, 4, 0, "R3", "code 0111 four zeros");
   endtask

   task automatic t_group3();
      one_case(1'b1, 5, 0, "R3", "code 110000 five ones");
      one_case(1'b0, 12, 0, "R3", "code 001111 twelve zeros");
      one_case(1'b0, 13, 0, "R10", "group 4 lowest length");
   endtask

   task automatic t_bubbles();
      one_case(1'b1, 9, 2, "R7", "idle cycles between bits");
   endtask

   task automatic t_back_to_back();
      expect_run(1'b0, 3);
      expect_run(1'b1, 7);
      send_code(1'b0, 3, 0);
      send_code(1'b1, 7, 0);
      drain();
      check_stream("R5", "two codewords in a row");
   endtask

   task automatic t_max_group();
      one_case(1'b1, (1 << (MAX_GRP + 1)) - 4, 0, "R10", "largest run ones");
      chk(stall_viol == 0, "R6", "ready low during emission", stall_viol, 0);
   endtask

   task automatic t_overflow(input logic pol, input string tag);
      do_reset();
      for (int i = 0; i < MAX_GRP; i++) push(pol, 0);
      chk(err == 1'b1, "R8", {tag, " err set"}, err, 1);
      chk(in_ready == 1'b1, "R8", {tag, " back to idle"}, in_ready, 1);
      repeat (3) @(negedge clk);
      chk(obuf.size() == 0, "R8", {tag, " no output"}, obuf.size(), 0);
      one_case(~pol, 3, 0, "R9", {tag, " decode after error"});
      chk(err == 1'b1, "R9", {tag, " err sticky"}, err, 1);
   endtask

   task automatic t_reset_clears();
      do_reset();
      chk(err == 1'b0, "R1", "reset clears err", err, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      do_reset();
      t_reset();
      t_group2();
      t_group3();
      t_bubbles();
      t_back_to_back();
      t_max_group();
      t_overflow(1'b1, "ones prefix");
      t_overflow(1'b0, "zeros prefix");
      t_reset_clears();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule